// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when the core of a small microcontroller is held in reset and for how long. Three causes feed it: a low-supply comparator flag, a deeper brown-out comparator flag and a timeout pulse from the watchdog timer. The block also reads a firmware mask for the low-supply detector, a suspend indicator and firmware writes to an external-oscillator enable bit. From these inputs it drives the core reset, a start-up wait flag and the clock-source select. It also keeps two sticky cause flags that firmware can read after the core restarts.

A supply-related reset always falls back to the internal clock. It then holds the core until the supply has recovered and a start-up interval has run out. A watchdog reset lasts a single cycle. It leaves the clock source unchanged and has no start-up interval. The brown-out flag is watched at all times. Once it trips, the low-supply flag is honoured again until start-up ends, even when firmware has masked it.

Top module: `rstseq_top`

## Requirements
- R1: While and after `por_n` is low, the core reset is high, the clock select is 0 (internal), the external-oscillator enable is 0, and the status word reads 0x10. Bit 4 is the supply cause and bit 6 is the watchdog cause.
- R2: A high `brown_det_i` raises `core_rst_o` combinationally. Once the synchronized flag takes effect, the clock select is 0, the oscillator enable is 0 and status bit 4 is 1.
- R3: After the last supply condition clears, the synchronized view takes two clock edges to see it. One further edge leaves the hold state. `start_wait_o` is then high for exactly TSTART cycles, and `core_rst_o` falls with it.
- R4: A supply reset that comes back during the start-up wait restarts the count. The final wait again lasts TSTART cycles.
- R5: `lowv_det_i` has no effect while `lowv_mask_i` or `suspend_i` is high. It takes effect again as soon as both are low.
- R6: After a brown-out, the low-supply flag keeps the core in reset until it clears, even with `lowv_mask_i` high. The TSTART wait follows.
- R7: A rising watchdog pulse in run state gives a one-cycle core reset with no start-up wait. It sets status bit 6, clears the oscillator enable and leaves the clock select unchanged.
- R8: The clock select takes the oscillator enable value only at the clock edge where `suspend_i` rises. A supply reset forces it to 0.
- R9: A status write clears each cause bit whose data bit is 0. Writing 1 leaves the bit unchanged, and the two bits are set independently. All other status bits read 0.
- R10: Watchdog pulses that arrive while the core is held in reset are dropped. They do not set status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| por_n | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| lowv_det_i | input | 1 | Low-supply comparator, 1 = supply below threshold |
| brown_det_i | input | 1 | Brown-out comparator, 1 = supply below brown-out level |
| wdog_tmo_i | input | 1 | Watchdog timeout, rising edge requests a reset |
| lowv_mask_i | input | 1 | Firmware mask for the low-supply detector |
| suspend_i | input | 1 | Suspend mode indicator |
| xosc_we_i | input | 1 | Write strobe for the oscillator enable bit |
| xosc_wd_i | input | 1 | Write data for the oscillator enable bit |
| stat_we_i | input | 1 | Write strobe for the status word |
| stat_wd_i | input | 8 | Status write data, 0 in a cause bit clears it |
| core_rst_o | output | 1 | Core reset, asserted asynchronously and released synchronously |
| start_wait_o | output | 1 | Start-up interval running |
| clk_ext_sel_o | output | 1 | Clock source, 1 = external oscillator |
| xosc_en_o | output | 1 | External-oscillator enable bit |
| status_o | output | 8 | Status word with sticky cause bits 4 and 6 |

## Verification
The assertions check several rules on every cycle. A start-up wait always implies core reset. A supply event always leaves the internal clock selected with bit 4 set. A watchdog event gives reset without a wait, sets bit 6 and keeps the clock select. The clock select moves only on a supply event or on suspend entry. Cause bits fall only after a clearing write, and the wait ends only at the timer limit or on a new supply event.

Some behaviours need the bench scenarios instead: the exact TSTART length, the restart of the count, masking and unmasking of the low-supply flag, the brown-out latch that holds reset through a masked detector, and dropped watchdog pulses. In these scenarios a behavioural model is compared with the design on every cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2,
    ST_WDR  = 2'd3
  } seq_st_e;

  localparam int unsigned VOLT_BIT = 4;
  localparam int unsigned WDOG_BIT = 6;
  localparam logic [7:0] CAUSE_MASK = 8'h50;

  // True on the last cycle of a span counted from zero
  function automatic logic span_last(input int unsigned cnt, input int unsigned span);
    return cnt == (span - 1);
  endfunction

  // Next status word: write-zero clears, then new causes are OR-ed in
  function automatic logic [7:0] cause_next(input logic [7:0] cur, input logic we,
                                            input logic [7:0] wdata, input logic [7:0] set);
    logic [7:0] keep;
    keep = we ? wdata : 8'hFF;
    return ((cur & keep) | set) & CAUSE_MASK;
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RST_VAL;
      out_q  <= RST_VAL;
    end else begin
      meta_q <= d;
      out_q  <= meta_q;
    end
  end

  assign q = out_q;
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
  import rstseq_pkg::*;
#(
  parameter int unsigned SPAN = 48,
  localparam int unsigned CW = $clog2(SPAN + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (run)     cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && span_last(32'(cnt_q), SPAN);
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       set_volt,
  input  logic       set_wdog,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] status
);
  logic [7:0] stat_q;
  logic [7:0] set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[VOLT_BIT] = set_volt;
    set_vec[WDOG_BIT] = set_wdog;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stat_q <= 8'h10;
    else         stat_q <= cause_next(stat_q, we, wdata, set_vec);
  end

  assign status = stat_q;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int unsigned TSTART = 48
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lowv_det_i,
  input  logic       brown_det_i,
  input  logic       wdog_tmo_i,
  input  logic       lowv_mask_i,
  input  logic       suspend_i,
  input  logic       xosc_we_i,
  input  logic       xosc_wd_i,
  input  logic       stat_we_i,
  input  logic [7:0] stat_wd_i,
  output logic       core_rst_o,
  output logic       start_wait_o,
  output logic       clk_ext_sel_o,
  output logic       xosc_en_o,
  output logic [7:0] status_o
);
  // Synchronized detector view: {watchdog, brown-out, low-supply}
  logic [2:0] det_s;
  logic       lowv_s, brown_s, wdog_s;

  rstseq_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      ({wdog_tmo_i, brown_det_i, lowv_det_i}),
    .q      (det_s)
  );
  assign lowv_s  = det_s[0];
  assign brown_s = det_s[1];
  assign wdog_s  = det_s[2];

  seq_st_e st_q;
  logic    force_q;
  logic    wdog_prev_q;
  logic    susp_prev_q;
  logic    xosc_q;
  logic    sel_q;

  // Named internal events
  logic lowv_live;
  logic vtrip_evt;
  logic wdr_evt;
  logic susp_rise;
  logic timer_done;
  logic timer_clr;
  logic timer_run;

  assign lowv_live = (!lowv_mask_i && !suspend_i) || force_q;
  assign vtrip_evt = brown_s || (lowv_s && lowv_live);
  assign wdr_evt   = (st_q == ST_RUN) && wdog_s && !wdog_prev_q && !vtrip_evt;
  assign susp_rise = suspend_i && !susp_prev_q;
  assign timer_clr = vtrip_evt || (st_q != ST_WAIT);
  assign timer_run = (st_q == ST_WAIT) && !vtrip_evt;

  rstseq_timer #(.SPAN(TSTART)) u_timer (
    .clk    (clk),
    .arst_n (por_n),
    .clr    (timer_clr),
    .run    (timer_run),
    .done   (timer_done)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q <= ST_HOLD;
    end else if (vtrip_evt) begin
      st_q <= ST_HOLD;
    end else begin
      unique case (st_q)
        ST_HOLD: st_q <= ST_WAIT;
        ST_WAIT: if (timer_done) st_q <= ST_RUN;
        ST_WDR:  st_q <= ST_RUN;
        default: if (wdr_evt) st_q <= ST_WDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      force_q     <= 1'b1;
      wdog_prev_q <= 1'b0;
      susp_prev_q <= 1'b0;
      xosc_q      <= 1'b0;
      sel_q       <= 1'b0;
    end else begin
      wdog_prev_q <= wdog_s;
      susp_prev_q <= suspend_i;
      if (vtrip_evt && brown_s) force_q <= 1'b1;
      else if (timer_done)      force_q <= 1'b0;
      if (vtrip_evt || wdr_evt) xosc_q <= 1'b0;
      else if (xosc_we_i)       xosc_q <= xosc_wd_i;
      if (vtrip_evt)            sel_q <= 1'b0;
      else if (susp_rise)       sel_q <= xosc_q;
    end
  end

  rstseq_cause u_cause (
    .clk      (clk),
    .arst_n   (por_n),
    .set_volt (vtrip_evt),
    .set_wdog (wdr_evt),
    .we       (stat_we_i),
    .wdata    (stat_wd_i),
    .status   (status_o)
  );

  // Asynchronous assertion, synchronous release through the state register
  assign core_rst_o    = !por_n || brown_det_i || (lowv_det_i && lowv_live) || (st_q != ST_RUN);
  assign start_wait_o  = (st_q == ST_WAIT);
  assign clk_ext_sel_o = sel_q;
  assign xosc_en_o     = xosc_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic clk,
  input logic por_n,
  input logic core_rst_o,
  input logic start_wait_o,
  input logic clk_ext_sel_o,
  input logic xosc_en_o,
  input logic volt_flag,
  input logic wdog_flag,
  input logic clr_volt_req,
  input logic clr_wdog_req,
  input logic vtrip_evt,
  input logic wdr_evt,
  input logic susp_rise,
  input logic timer_done
);
  // R3: the start-up wait never runs with the core released
  a_r3_wait_holds_core: assert property (@(posedge clk) disable iff (!por_n)
    start_wait_o |-> core_rst_o);

  // R3: the wait ends only at the timer limit or on a new supply event
  a_r3_wait_exit: assert property (@(posedge clk) disable iff (!por_n)
    $fell(start_wait_o) |-> $past(timer_done || vtrip_evt));

  // R2: a supply event selects the internal clock, drops the enable, records bit 4
  a_r2_volt_internal_clock: assert property (@(posedge clk) disable iff (!por_n)
    vtrip_evt |=> (!clk_ext_sel_o && !xosc_en_o && volt_flag));

  // R7: a watchdog event resets without a wait and records bit 6
  a_r7_wdr_pulse: assert property (@(posedge clk) disable iff (!por_n)
    wdr_evt |=> (core_rst_o && !start_wait_o && wdog_flag && !xosc_en_o));

  // R7: the watchdog leaves the clock source alone
  a_r7_wdr_keeps_clock: assert property (@(posedge clk) disable iff (!por_n)
    (wdr_evt && !susp_rise) |=> $stable(clk_ext_sel_o));

  // R8: the clock select moves only on a supply event or suspend entry
  a_r8_sel_moves_only: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(clk_ext_sel_o) |-> $past(vtrip_evt || susp_rise));

  // R9: cause bits fall only after a clearing write
  a_r9_volt_clear: assert property (@(posedge clk) disable iff (!por_n)
    $fell(volt_flag) |-> $past(clr_volt_req));

  a_r9_wdog_clear: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wdog_flag) |-> $past(clr_wdog_req));
endmodule

bind rstseq_top rstseq_chk u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .core_rst_o    (core_rst_o),
  .start_wait_o  (start_wait_o),
  .clk_ext_sel_o (clk_ext_sel_o),
  .xosc_en_o     (xosc_en_o),
  .volt_flag     (status_o[4]),
  .wdog_flag     (status_o[6]),
  .clr_volt_req  (stat_we_i && !stat_wd_i[4]),
  .clr_wdog_req  (stat_we_i && !stat_wd_i[6]),
  .vtrip_evt     (vtrip_evt),
  .wdr_evt       (wdr_evt),
  .susp_rise     (susp_rise),
  .timer_done    (timer_done)
);

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
  localparam int T = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_n = 1'b0, lv = 1'b1, bo = 1'b0, wd = 1'b0, mask = 1'b0, susp = 1'b0;
  logic xwe = 1'b0, xwd = 1'b0, swe = 1'b0;
  logic [7:0] swd = 8'h00;
  logic core_rst, start_wait, sel, xosc;
  logic [7:0] status;

  rstseq_top #(.TSTART(T)) u0 (
    .clk(clk), .por_n(por_n), .lowv_det_i(lv), .brown_det_i(bo), .wdog_tmo_i(wd),
    .lowv_mask_i(mask), .suspend_i(susp), .xosc_we_i(xwe), .xosc_wd_i(xwd),
    .stat_we_i(swe), .stat_wd_i(swd), .core_rst_o(core_rst), .start_wait_o(start_wait),
    .clk_ext_sel_o(sel), .xosc_en_o(xosc), .status_o(status)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit model_on = 1'b0;

  // Behavioural reference: 0 run, 1 hold, 2 wait, 3 watchdog pulse
  int   m_st = 1, m_cnt = 0;
  bit   m_force = 1, m_volt = 1, m_wdc = 0, m_xosc = 0, m_sel = 0;
  bit   q_lv[2] = '{1, 1};
  bit   q_bo[2] = '{0, 0};
  bit   q_wd[2] = '{0, 0};
  bit   m_wdprev = 0, m_suspprev = 0;

  always @(posedge clk) begin
    if (!por_n) begin
      m_st = 1; m_cnt = 0; m_force = 1; m_volt = 1; m_wdc = 0; m_xosc = 0; m_sel = 0;
      q_lv = '{1, 1}; q_bo = '{0, 0}; q_wd = '{0, 0}; m_wdprev = 0; m_suspprev = 0;
    end else begin
      bit live, vt, wrise, srise, wdr, done;
      live  = (!mask && !susp) || m_force;
      vt    = q_bo[1] || (q_lv[1] && live);
      wrise = q_wd[1] && !m_wdprev;
      srise = susp && !m_suspprev;
      wdr   = (m_st == 0) && wrise && !vt;
      done  = (m_st == 2) && !vt && (m_cnt == T - 1);
      if (swe && !swd[4]) m_volt = 0;
      if (swe && !swd[6]) m_wdc = 0;
      if (srise && !vt) m_sel = m_xosc;
      if (vt || wdr) m_xosc = 0; else if (xwe) m_xosc = xwd;
      if (vt) begin
        m_st = 1; m_cnt = 0; m_volt = 1; m_sel = 0;
        if (q_bo[1]) m_force = 1;
      end else if (m_st == 1) begin
        m_st = 2; m_cnt = 0;
      end else if (m_st == 2) begin
        if (done) begin m_st = 0; m_force = 0; end else m_cnt++;
      end else if (m_st == 3) begin
        m_st = 0;
      end else if (wdr) begin
        m_st = 3; m_wdc = 1;
      end
      m_wdprev = q_wd[1]; m_suspprev = susp;
      q_lv[1] = q_lv[0]; q_lv[0] = lv;
      q_bo[1] = q_bo[0]; q_bo[0] = bo;
      q_wd[1] = q_wd[0]; q_wd[0] = wd;
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    bit e_rst;
    @(negedge clk);
    cyc++;
    if (model_on) begin
      e_rst = (m_st != 0) || bo || (lv && ((!mask && !susp) || m_force));
      chk("R3", "core_rst", {7'd0, core_rst}, {7'd0, e_rst});
      chk("R3", "start_wait", {7'd0, start_wait}, {7'd0, m_st == 2});
      chk("R8", "clk_sel", {7'd0, sel}, {7'd0, m_sel});
      chk("R7", "xosc_en", {7'd0, xosc}, {7'd0, m_xosc});
      chk("R9", "status", status, {1'b0, m_wdc, 1'b0, m_volt, 4'd0});
    end
  endtask

  // Runs until the core is released; returns last contiguous wait run and total wait cycles
  task automatic run_out(output int last_run, output int total);
    int run = 0;
    total = 0;
    last_run = 0;
    for (int k = 0; k < 6 * T + 20; k++) begin
      tick();
      if (start_wait) begin run++; total++; end
      else if (run != 0) begin last_run = run; run = 0; end
      if (!core_rst) break;
    end
    if (run != 0) last_run = run;
  endtask

  task automatic wstat(input logic [7:0] d);
    swe = 1'b1; swd = d; tick(); swe = 1'b0; swd = 8'h00;
  endtask

  initial begin
    int lr, tot, r, sw;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    model_on = 1'b1;
    tick();
    // R1 reset state
    chk("R1", "core_rst after por", {7'd0, core_rst}, 8'd1);
    chk("R1", "status after por", status, 8'h10);
    chk("R1", "clk_sel after por", {7'd0, sel}, 8'd0);
    chk("R1", "xosc after por", {7'd0, xosc}, 8'd0);

    // R3 start-up length
    lv = 1'b0;
    run_out(lr, tot);
    chk("R3", "wait length", 8'(lr), 8'(T));
    chk("R3", "released", {7'd0, core_rst}, 8'd0);

    // R8 clock select follows enable only at suspend entry
    xwe = 1'b1; xwd = 1'b1; tick(); xwe = 1'b0; tick();
    chk("R8", "sel before suspend", {7'd0, sel}, 8'd0);
    susp = 1'b1; tick();
    chk("R8", "sel at suspend entry", {7'd0, sel}, 8'd1);
    susp = 1'b0; tick();

    // R7 watchdog reset
    wd = 1'b1; tick(); tick(); wd = 1'b0;
    r = 0; sw = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (core_rst) r++;
      if (start_wait) sw++;
    end
    chk("R7", "wdr reset cycles", 8'(r), 8'd1);
    chk("R7", "wdr no wait", 8'(sw), 8'd0);
    chk("R7", "wdr keeps clk_sel", {7'd0, sel}, 8'd1);
    chk("R7", "wdr status", status, 8'h50);
    chk("R7", "wdr clears xosc", {7'd0, xosc}, 8'd0);

    // R9 write-zero clearing
    wstat(8'hFF);
    chk("R9", "write ones no effect", status, 8'h50);
    wstat(8'hEF);
    chk("R9", "clear bit4 only", status, 8'h40);
    wstat(8'hBF);
    chk("R9", "clear bit6", status, 8'h00);

    // R5 masked and suspended low-supply flag
    mask = 1'b1; lv = 1'b1;
    repeat (6) tick();
    chk("R5", "masked lowv ignored", {7'd0, core_rst}, 8'd0);
    chk("R5", "masked lowv no cause", status, 8'h00);
    mask = 1'b0; tick();
    chk("R5", "unmask resets", {7'd0, core_rst}, 8'd1);
    lv = 1'b0; run_out(lr, tot);
    susp = 1'b1; lv = 1'b1;
    repeat (6) tick();
    chk("R5", "suspend lowv ignored", {7'd0, core_rst}, 8'd0);
    susp = 1'b0; tick();
    chk("R5", "suspend exit resets", {7'd0, core_rst}, 8'd1);
    lv = 1'b0; run_out(lr, tot);
    wstat(8'h00);

    // R4 restart of the count
    lv = 1'b1; repeat (4) tick(); lv = 1'b0;
    for (int k = 0; k < 20 && !start_wait; k++) tick();
    repeat (T / 2) tick();
    lv = 1'b1; tick(); tick(); lv = 1'b0;
    run_out(lr, tot);
    chk("R4", "final wait length", 8'(lr), 8'(T));
    chk("R4", "restarted total", {7'd0, tot >= T}, 8'd1);
    chk("R4", "released", {7'd0, core_rst}, 8'd0);

    // R2 and R6 brown-out with masked low-supply flag
    xwe = 1'b1; xwd = 1'b1; tick(); xwe = 1'b0;
    susp = 1'b1; tick(); susp = 1'b0; tick();
    chk("R8", "sel before brown-out", {7'd0, sel}, 8'd1);
    wstat(8'h00);
    mask = 1'b1; lv = 1'b1; bo = 1'b1;
    tick();
    chk("R2", "brown-out resets", {7'd0, core_rst}, 8'd1);
    repeat (3) tick();
    bo = 1'b0;
    repeat (3 * T) tick();
    chk("R6", "held by lowv despite mask", {7'd0, core_rst}, 8'd1);
    chk("R2", "internal clock", {7'd0, sel}, 8'd0);
    chk("R2", "xosc cleared", {7'd0, xosc}, 8'd0);
    chk("R2", "cause bit4", status, 8'h10);
    lv = 1'b0;
    run_out(lr, tot);
    chk("R6", "wait after brown-out", 8'(lr), 8'(T));
    mask = 1'b0; tick();

    // R10 watchdog dropped while held
    wstat(8'h00);
    lv = 1'b1; repeat (3) tick(); lv = 1'b0;
    repeat (4) tick();
    wd = 1'b1; tick(); tick(); wd = 1'b0;
    run_out(lr, tot);
    repeat (4) tick();
    chk("R10", "no watchdog cause", status, 8'h10);
    chk("R10", "running", {7'd0, core_rst}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule